// File: doc/BRIEF.md
# Error-Tolerant Approximate Adder

This block adds two unsigned operands of a configurable width and trades a bounded amount of accuracy in the low-order bits for a shorter carry path. The operand is cut into an upper exact section and a lower approximate section. The upper section is a plain ripple-carry adder whose carry-in is zero. Its carry-out becomes the top bit of the one-bit-wider result. No carry crosses from the lower section into the upper one.

The lower section has no carry chain. A fill-detect stage looks for the highest bit position of the lower section where both operands hold a 1. Above that position each result bit is the XOR of the operand bits. At that position and at every bit below it the result is forced to 1. The detect stage can be built either as a simple top-down OR chain or as a grouped structure. In the grouped form, a per-group bypass carries a hit past whole groups to all lower groups. An optional output register, with a valid flag, lets the adder sit in a pipeline.

Top module: `apx_err_adder`

## Requirements
- R1: Result bits W down to LO_W equal the exact sum of the upper operand slices op_a[W-1:LO_W] + op_b[W-1:LO_W], and that sum's carry-out appears on bit W.
- R2: The lower operand slices never affect result bits W down to LO_W.
- R3: Every lower-section result bit that lies above the highest position where both operands are 1 equals op_a XOR op_b at that bit.
- R4: At the highest lower-section position where both operands are 1, and at every lower position, the result bit is 1.
- R5: When no lower-section position has both operand bits at 1, the lower result equals op_a XOR op_b, which is also the exact lower sum.
- R6: The result never exceeds the exact sum, and the exact sum minus the result is below 2^LO_W.
- R7: With W=16 and LO_W=8, adding 45657 and 56724 gives 102367.
- R8: The grouped and the chained detect styles give identical results for every input.
- R9: With REGISTERED=1, out_valid is high one clock after a cycle with in_valid high, and sum then holds the result for the operands captured in that cycle.
- R10: A synchronous active-high rst clears out_valid.
- R11: After a clock with in_valid low, out_valid is low and sum keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on op_a/op_b are valid this cycle |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| sum | output | W+1 | Approximate sum |
| out_valid | output | 1 | sum carries a fresh result |

## Verification
Random operand pairs show the fill and XOR regions together. Each random result is also held against the exact-sum bound. Pairs built as b = ~a have no double-one, so any difference from the exact sum there points to a spurious fill. A double-one placed only at the top of the lower section must fill the whole section, while one placed only at bit 0 must fill that bit alone; these two cases separate an off-by-one in the thermometer from a correct one. All-zero and all-ones operands exercise the carry-out of the exact section. Pairs that share upper slices but differ in the lower slices expose any leak across the section boundary.

// File: rtl/apx_add_pkg.sv
package apx_add_pkg;

   typedef enum logic {
      CTL_CHAIN   = 1'b0,
      CTL_GROUPED = 1'b1
   } apx_ctl_style_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/apx_exact_rca.sv
module apx_exact_rca #(
   parameter int WIDTH = 12
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   output logic [WIDTH:0]   s
);

   logic [WIDTH:0] cy;

   assign cy[0] = 1'b0;

   for (genvar i = 0; i < WIDTH; i++) begin : g_fa
      assign s[i]    = x[i] ^ y[i] ^ cy[i];
      assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
   end

   assign s[WIDTH] = cy[WIDTH];

endmodule

// File: rtl/apx_fill_detect.sv
module apx_fill_detect
   import apx_add_pkg::*;
#(
   parameter int             WIDTH = 20,
   parameter int             GRP   = 4,
   parameter apx_ctl_style_e STYLE = CTL_GROUPED
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   output logic [WIDTH-1:0] ctl
);

   localparam int NGRP = ceil_div(WIDTH, GRP);
   localparam int PADW = NGRP * GRP;

   logic [WIDTH-1:0] both;
   assign both = x & y;

   if (STYLE == CTL_CHAIN) begin : g_chain
      always_comb begin
         logic seen;
         seen = 1'b0;
         for (int i = WIDTH - 1; i >= 0; i--) begin
            seen   = seen | both[i];
            ctl[i] = seen;
         end
      end
   end else begin : g_grouped
      logic [PADW-1:0] both_pad;
      logic [PADW-1:0] ctl_pad;
      logic [NGRP-1:0] grp_hit;
      logic [NGRP:0]   grp_byp;

      assign both_pad = PADW'(both);
      assign grp_byp[NGRP] = 1'b0;

      for (genvar g = NGRP - 1; g >= 0; g--) begin : g_grp
         assign grp_hit[g] = |both_pad[g*GRP +: GRP];
         assign grp_byp[g] = grp_byp[g+1] | grp_hit[g];
         for (genvar k = 0; k < GRP; k++) begin : g_cell
            assign ctl_pad[g*GRP + k] = grp_byp[g+1] | (|both_pad[g*GRP + GRP - 1 : g*GRP + k]);
         end
      end

      assign ctl = ctl_pad[WIDTH-1:0];
   end

endmodule

// File: rtl/apx_fill_sum.sv
module apx_fill_sum #(
   parameter int WIDTH = 20
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic [WIDTH-1:0] ctl,
   output logic [WIDTH-1:0] s
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign s[i] = ctl[i] ? 1'b1 : (x[i] ^ y[i]);
   end

endmodule

// File: rtl/apx_err_adder.sv
module apx_err_adder
   import apx_add_pkg::*;
#(
   parameter int             W          = 32,
   parameter int             LO_W       = 20,
   parameter int             GRP        = 4,
   parameter apx_ctl_style_e CTL_STYLE  = CTL_GROUPED,
   parameter bit             REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic [W:0]   sum,
   output logic         out_valid
);

   localparam int HI_W = W - LO_W;

   if (LO_W < 1 || LO_W >= W) begin : g_bad_split
      $error("apx_err_adder: LO_W must lie in 1..W-1");
   end
   if (GRP < 1 || GRP > LO_W) begin : g_bad_grp
      $error("apx_err_adder: GRP must lie in 1..LO_W");
   end

   logic [LO_W-1:0] lo_a, lo_b, fill_ctl, lo_sum;
   logic [HI_W-1:0] hi_a, hi_b;
   logic [HI_W:0]   hi_sum;
   logic [W:0]      comb_sum;

   assign lo_a = op_a[LO_W-1:0];
   assign lo_b = op_b[LO_W-1:0];
   assign hi_a = op_a[W-1:LO_W];
   assign hi_b = op_b[W-1:LO_W];

   apx_exact_rca #(.WIDTH(HI_W)) u_hi (
      .x(hi_a),
      .y(hi_b),
      .s(hi_sum)
   );

   apx_fill_detect #(.WIDTH(LO_W), .GRP(GRP), .STYLE(CTL_STYLE)) u_det (
      .x  (lo_a),
      .y  (lo_b),
      .ctl(fill_ctl)
   );

   apx_fill_sum #(.WIDTH(LO_W)) u_lo (
      .x  (lo_a),
      .y  (lo_b),
      .ctl(fill_ctl),
      .s  (lo_sum)
   );

   assign comb_sum = {hi_sum, lo_sum};

   if (REGISTERED) begin : g_reg
      logic [W:0] sum_q;
      logic       vld_q;
      always_ff @(posedge clk) begin
         if (rst) vld_q <= 1'b0;
         else     vld_q <= in_valid;
         if (in_valid) sum_q <= comb_sum;
      end
      assign sum       = sum_q;
      assign out_valid = vld_q;
   end else begin : g_comb
      assign sum       = comb_sum;
      assign out_valid = in_valid;
   end

endmodule

// File: rtl/apx_err_adder_chk.sv
module apx_err_adder_chk #(
   parameter int W          = 32,
   parameter int LO_W       = 20,
   parameter bit REGISTERED = 1'b1
) (
   input logic            clk,
   input logic            rst,
   input logic            in_valid,
   input logic            out_valid,
   input logic [W-1:0]    op_a,
   input logic [W-1:0]    op_b,
   input logic [W:0]      comb_sum,
   input logic [LO_W-1:0] fill_ctl,
   input logic [W:0]      sum
);

   localparam int         HI_W = W - LO_W;
   localparam logic [W:0] LIM  = (W+1)'(1) << LO_W;

   logic [W:0]      exact;
   logic [LO_W-1:0] lo_a, lo_b, lo_res;
   logic [HI_W:0]   hi_ref;

   assign exact  = {1'b0, op_a} + {1'b0, op_b};
   assign lo_a   = op_a[LO_W-1:0];
   assign lo_b   = op_b[LO_W-1:0];
   assign lo_res = comb_sum[LO_W-1:0];
   assign hi_ref = {1'b0, op_a[W-1:LO_W]} + {1'b0, op_b[W-1:LO_W]};

   p_upper_exact_r1: assert property (@(posedge clk) disable iff (rst)
      comb_sum[W:LO_W] == hi_ref);

   p_xor_above_r3: assert property (@(posedge clk) disable iff (rst)
      (lo_res & ~fill_ctl) == ((lo_a ^ lo_b) & ~fill_ctl));

   p_thermo_shape_r4: assert property (@(posedge clk) disable iff (rst)
      ((fill_ctl + LO_W'(1)) & fill_ctl) == '0);

   p_hit_covered_r4: assert property (@(posedge clk) disable iff (rst)
      ((lo_a & lo_b) & ~fill_ctl) == '0);

   p_no_hit_exact_r5: assert property (@(posedge clk) disable iff (rst)
      (fill_ctl == '0) |-> (lo_res == lo_a + lo_b));

   p_err_bound_r6: assert property (@(posedge clk) disable iff (rst)
      (comb_sum <= exact) && ((exact - comb_sum) < LIM));

   if (REGISTERED) begin : g_reg_chk
      p_valid_lag_r9: assert property (@(posedge clk) disable iff (rst)
         out_valid |-> $past(in_valid));

      p_data_lag_r9: assert property (@(posedge clk) disable iff (rst)
         out_valid |-> sum == $past(comb_sum));

      p_reset_clear_r10: assert property (@(posedge clk)
         $past(rst) |-> !out_valid);

      p_hold_r11: assert property (@(posedge clk) disable iff (rst)
         !$past(in_valid) |-> (!out_valid && $stable(sum)));
   end

endmodule

bind apx_err_adder apx_err_adder_chk #(
   .W(W), .LO_W(LO_W), .REGISTERED(REGISTERED)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .out_valid(out_valid),
   .op_a     (op_a),
   .op_b     (op_b),
   .comb_sum (comb_sum),
   .fill_ctl (fill_ctl),
   .sum      (sum)
);

// File: tb/sim_apx_err_adder.sv
module sim_apx_err_adder;
   import apx_add_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 32;
   localparam int LO = 20;

   typedef struct {
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic [W:0]   exp;
      string        tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [W-1:0]  op_a = '0, op_b = '0;
   logic [W:0]    sum_g, sum_c;
   logic          vld_g, vld_c;
   logic [15:0]   s_a = '0, s_b = '0;
   logic [16:0]   s_sum;
   logic          s_vld;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   item_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   apx_err_adder #(.W(W), .LO_W(LO), .CTL_STYLE(CTL_GROUPED)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .sum(sum_g), .out_valid(vld_g));

   apx_err_adder #(.W(W), .LO_W(LO), .CTL_STYLE(CTL_CHAIN)) u_chain (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .sum(sum_c), .out_valid(vld_c));

   apx_err_adder #(.W(16), .LO_W(8), .GRP(3), .REGISTERED(1'b0)) u_small (
      .clk(clk), .rst(rst), .in_valid(1'b1), .op_a(s_a), .op_b(s_b),
      .sum(s_sum), .out_valid(s_vld));

   function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-LO:0] up;
      logic [LO-1:0] low, dd;
      logic [31:0]   mask;
      int top;
      up  = {1'b0, a[W-1:LO]} + {1'b0, b[W-1:LO]};
      dd  = a[LO-1:0] & b[LO-1:0];
      low = a[LO-1:0] ^ b[LO-1:0];
      top = -1;
      for (int i = 0; i < LO; i++) if (dd[i]) top = i;
      if (top >= 0) begin
         mask = (32'd1 << (top + 1)) - 32'd1;
         low  = low | mask[LO-1:0];
      end
      return {up, low};
   endfunction

   task automatic check(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
      item_t it;
      @(negedge clk);
      op_a = a; op_b = b; in_valid = 1'b1;
      it.a = a; it.b = b; it.exp = model(a, b); it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && vld_g) begin
            if (sb.size() == 0) begin
               check(1'b0, "R9 (unexpected out_valid)", sum_g, '0);
            end else begin
               item_t it;
               logic [W:0] ex;
               it = sb.pop_front();
               ex = {1'b0, it.a} + {1'b0, it.b};
               check(sum_g == it.exp, it.tag, sum_g, it.exp);
               check(sum_g <= ex && (ex - sum_g) < ((W+1)'(1) << LO), "R6 bound", ex - sum_g, '0);
               check(sum_g[W:LO] == ({1'b0, it.a[W-1:LO]} + {1'b0, it.b[W-1:LO]}), "R1 upper",
                     (W+1)'(sum_g[W:LO]), (W+1)'({1'b0, it.a[W-1:LO]} + {1'b0, it.b[W-1:LO]}));
               check(vld_c && sum_c == sum_g, "R8 styles agree", sum_c, sum_g);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W:0] held;
      repeat (3) @(negedge clk);
      check(vld_g == 1'b0, "R10 reset clears out_valid", (W+1)'(vld_g), '0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(vld_g == 1'b0, "R10 idle after reset", (W+1)'(vld_g), '0);

      push('0, '0, "R5 all zeros");
      push('1, '1, "R4 all ones");
      push(32'h0008_0000, 32'h0008_0000, "R4 double-one at low MSB");
      push(32'h0000_0001, 32'h0000_0001, "R4 double-one at bit 0");
      push(32'h1234_5000 | 32'h0000_0A5A, 32'h1234_5000 & 32'hFFF0_0000 | 32'h0000_05A5, "R5 no double-one");
      push(32'hABC1_2345, 32'h0010_0321, "R3 xor above fill");
      push(32'h7FF0_0000 | 32'h000F_0F0F, 32'h0010_0000 | 32'h0000_F0F0, "R2 upper carry-out");
      push(32'h7FF0_0000 | 32'h0008_0001, 32'h0010_0000 | 32'h0008_0001, "R2 same upper, other lower");
      for (int i = 0; i < 40; i++) begin
         logic [W-1:0] r;
         r = $urandom;
         push(r, $urandom, "R3 random");
         push(r, ~r, "R5 random no double-one");
      end

      @(negedge clk);
      in_valid = 1'b0;
      op_a = 32'hDEAD_BEEF; op_b = 32'h1357_9BDF;
      held = sum_g;
      @(negedge clk);
      check(vld_g == 1'b0, "R11 out_valid drops", (W+1)'(vld_g), '0);
      check(sum_g == held, "R11 sum holds", sum_g, held);
      @(negedge clk);
      check(sb.size() == 0, "R9 all results delivered", (W+1)'(sb.size()), '0);

      @(negedge clk);
      rst = 1'b1; in_valid = 1'b1;
      @(negedge clk);
      check(vld_g == 1'b0, "R10 reset beats in_valid", (W+1)'(vld_g), '0);
      rst = 1'b0; in_valid = 1'b0;

      s_a = 16'd45657; s_b = 16'd56724;
      #1;
      check(s_sum == 17'd102367, "R7 worked example", (W+1)'(s_sum), 33'd102367);
      s_a = 16'h0101; s_b = 16'h0101;
      #1;
      check(s_sum == 17'd513, "R4 small fill at bit 0", (W+1)'(s_sum), 33'd513);
      s_a = 16'h00F0; s_b = 16'h000F;
      #1;
      check(s_sum == 17'd255, "R5 small no double-one", (W+1)'(s_sum), 33'd255);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule